// File: doc/BRIEF.md
# Parallel Port Run-Length Expander

This block sits on the receive side of an enhanced parallel port. Items arrive from the port one byte at a time, each marked as either a command or a data byte. The block turns them into a plain byte stream for the receive buffer. A command with its top bit clear holds a repeat count that applies to the next data byte. A command with its top bit set holds a channel number, which the block keeps in a register. A data byte is sent out once plus the pending count, so a count of N gives N+1 copies. A data byte with no pending count goes out once, unchanged.

Both streams use valid/ready. An input item is taken on a clock edge where `in_valid` and `in_ready` are both high. An output byte is taken on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_byte` keeps its value and no new item is accepted. `in_ready` stays low while copies of a run remain to be sent. On the edge that takes the last copy of a run, the block can accept the next item, so a stream of single bytes flows with no gaps. The block expands runs only; it does not compress.

Top module: `rle_expander`

## Requirements
- R1: A command byte with bit 7 = 0 stores bits 6:0 as the pending repeat count and produces no output byte.
- R2: A command byte with bit 7 = 1 loads bits 6:0 into `chan_addr` one edge after it is accepted and produces no output byte.
- R3: A data byte accepted with pending count N is sent out N+1 times in a row with its value unchanged. The first copy is valid right after the accepting edge.
- R4: A pending count of 0 makes the next data byte go out exactly once.
- R5: A pending count of 127 makes the next data byte go out exactly 128 times.
- R6: A data byte with no pending count is sent out once. A count is used up by the data byte that takes it, so the data byte after that goes out once.
- R7: A channel command clears any pending count.
- R8: A count command that arrives while another count is pending replaces it.
- R9: While copies of a run remain, or while `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_byte` is held.
- R10: After reset, `out_valid` is 0, `chan_addr` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Block can accept an input item |
| in_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| in_byte | input | 8 | Input item value |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_byte | output | 8 | Expanded output byte |
| chan_addr | output | 7 | Most recent channel number |

## Verification
A data byte taken on edge k is on `out_byte` with `out_valid` high right after edge k, because it passes through one register. When `out_ready` stays high, its copies take edges k+1 through k+N+1. A channel command shows on `chan_addr` right after the edge that accepts it. The bench changes inputs just after each rising edge and reads outputs on the falling edge. It records each output transfer on the falling edge before the edge that takes it, then compares the recorded stream with the expected one once the output has been idle for several cycles.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_COUNT = 2'd1,
    KIND_CHAN  = 2'd2
  } item_kind_e;
endpackage

// File: rtl/rle_cmd_decode.sv
module rle_cmd_decode
  import rle_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] item,
  output item_kind_e        kind,
  output logic [DATA_W-2:0] field
);
  // The top bit of a command selects between a count and a channel number.
  always_comb begin
    field = item[DATA_W-2:0];
    if (!is_cmd)                kind = KIND_DATA;
    else if (item[DATA_W-1])    kind = KIND_CHAN;
    else                        kind = KIND_COUNT;
  end
endmodule

// File: rtl/rle_repeat_stage.sv
module rle_repeat_stage #(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic [CNT_W-1:0]  load_rem,
  input  logic              out_ready,
  output logic              can_load,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte
);
  logic [CNT_W-1:0] rem_q;   // copies still to send after the current one

  assign can_load = !out_valid || (out_ready && (rem_q == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      rem_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_byte  <= load_byte;
      rem_q     <= load_rem;
    end else if (out_valid && out_ready) begin
      if (rem_q == '0) out_valid <= 1'b0;
      else             rem_q     <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/rle_expander.sv
module rle_expander
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_cmd,
  input  logic [DATA_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_byte,
  output logic [CNT_W-1:0]  chan_addr
);
  item_kind_e       kind;
  logic [CNT_W-1:0] field;
  logic [CNT_W-1:0] pend_cnt_q;
  logic             pend_vld_q;
  logic             accept;
  logic             load;
  logic             can_load;

  rle_cmd_decode #(.DATA_W(DATA_W)) u_decode (
    .is_cmd (in_is_cmd),
    .item   (in_byte),
    .kind   (kind),
    .field  (field)
  );

  assign in_ready = can_load;
  assign accept   = in_valid && can_load;
  assign load     = accept && (kind == KIND_DATA);

  rle_repeat_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_byte (in_byte),
    .load_rem  (pend_vld_q ? pend_cnt_q : '0),
    .out_ready (out_ready),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_byte  (out_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_cnt_q <= '0;
      pend_vld_q <= 1'b0;
      chan_addr  <= '0;
    end else if (accept) begin
      unique case (kind)
        KIND_COUNT: begin
          pend_cnt_q <= field;
          pend_vld_q <= 1'b1;
        end
        KIND_CHAN: begin
          chan_addr  <= field;
          pend_vld_q <= 1'b0;
        end
        default: pend_vld_q <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_is_cmd,
  input logic [DATA_W-1:0] in_byte,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_byte,
  input logic [DATA_W-2:0] chan_addr
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R9
  AST_NO_ACCEPT_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9
  AST_DATA_FIRST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_is_cmd) |=> (out_valid && out_byte == $past(in_byte))); // R3
  AST_CMD_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_is_cmd) |=> !out_valid); // R1
  AST_CHAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_is_cmd && in_byte[DATA_W-1])
      |=> (chan_addr == $past(in_byte[DATA_W-2:0]))); // R2
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R10
endmodule

bind rle_expander rle_expander_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_rle_expander.sv
module test_rle_expander;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_is_cmd = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;
  logic [6:0] chan_addr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] got[$];

  always #4 clk = ~clk;

  rle_expander i_rle_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_cmd(in_is_cmd), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .chan_addr(chan_addr)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) got.push_back(out_byte);

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(bit cmd, logic [7:0] b);
    in_valid = 1'b1; in_is_cmd = cmd; in_byte = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int idle = 0;
    while (idle < 4) begin
      @(negedge clk);
      if (out_valid) idle = 0; else idle++;
    end
    @(posedge clk); #1;
  endtask

  task automatic expect_run(string req, logic [7:0] val, int n);
    int bad = 0;
    check(req, got.size(), n);
    foreach (got[i]) if (got[i] != val) bad++;
    check(req, bad, 0);
    got.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 out_valid", out_valid, 0);
    check("R10 chan_addr", chan_addr, 0);
    check("R10 in_ready", in_ready, 1);
  endtask

  task automatic t_plain();
    send(0, 8'hC3); drain(); expect_run("R6 plain", 8'hC3, 1);
    send(0, 8'h00); send(0, 8'hFF); drain();
    check("R6 two plain count", got.size(), 2);
    if (got.size() == 2) begin
      check("R6 first", got[0], 8'h00);
      check("R6 second", got[1], 8'hFF);
    end
    got.delete();
  endtask

  task automatic t_counts();
    send(1, 8'h05); send(0, 8'h11);
    @(negedge clk);
    check("R9 in_ready low in run", in_ready, 0);
    drain(); expect_run("R3 count 5", 8'h11, 6);
    send(0, 8'h22); drain(); expect_run("R6 count used", 8'h22, 1);
    send(1, 8'h00); send(0, 8'h33); drain(); expect_run("R4 count 0", 8'h33, 1);
    send(1, 8'h7F); send(0, 8'h44); drain(); expect_run("R5 count 127", 8'h44, 128);
    send(1, 8'h01); drain(); check("R1 no output", got.size(), 0);
    send(0, 8'h55); drain(); expect_run("R1 count 1", 8'h55, 2);
  endtask

  task automatic t_replace();
    send(1, 8'h09); send(1, 8'h02); send(0, 8'h66); drain();
    expect_run("R8 replace", 8'h66, 3);
  endtask

  task automatic t_channel();
    send(1, 8'hAA); drain();
    check("R2 chan_addr", chan_addr, 8'h2A);
    check("R2 no output", got.size(), 0);
    send(1, 8'h04); send(1, 8'h85); send(0, 8'h77); drain();
    check("R2 chan_addr second", chan_addr, 5);
    expect_run("R7 chan clears count", 8'h77, 1);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    send(1, 8'h03);
    in_valid = 1'b1; in_is_cmd = 1'b0; in_byte = 8'h5A;
    @(posedge clk); #1; in_valid = 1'b0;
    in_is_cmd = 1'b1; in_byte = 8'h81; in_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 valid held", out_valid, 1);
      check("R9 byte held", out_byte, 8'h5A);
      check("R9 in_ready low", in_ready, 0);
    end
    in_valid = 1'b0;
    @(posedge clk); #1;
    out_ready = 1'b1;
    drain();
    expect_run("R9 run after stall", 8'h5A, 4);
    check("R9 stalled cmd ignored", chan_addr, 5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    @(posedge clk); #1;
    t_plain();
    t_counts();
    t_replace();
    t_channel();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule